// File: doc/BRIEF.md
# Two-Level Supply Brownout Supervisor

This block sequences a mixed-signal device through power-up, brownout and power loss. Two comparator flags arrive from outside. One says the supply is above a low level, below which digital state cannot be trusted. The other says the supply is above a higher level, which is needed for analog operation. Both flags pass through synchronizers, and the supervisor then decides four things: whether the outputs and the analog circuitry may run, whether volatile settings must be held at their defaults, and whether the nonvolatile configuration has to be copied into the shadow register bank again.

A shallow dip, where the supply falls below the analog level but stays above the digital level, only disables the outputs and the analog circuitry. The copied settings stay valid, so on recovery the block returns to normal operation without another copy. A deep dip below the digital level clears everything. The next rise above the analog level then starts a fresh copy, carried out as a request/done handshake with the nonvolatile store. A 2-bit status output reports which of the four states the supervisor is in.

Top module: `supply_supervisor`

## Requirements
- R1: After reset the state is off: status is 0, `outputs_en`, `analog_en`, `recall_req` and `shadow_valid` are 0, and `vol_clear` is 1.
- R2: Each comparator flag passes through two synchronizer flops before the state register. A change driven between clock edges shows at the outputs only after the third rising edge, and not after the second.
- R3: In the off state, both flags at 1 move the block to recalling (status 1). In that state `recall_req` stays 1 and outputs and analog stay disabled until `recall_done` is seen.
- R4: `recall_done` high while recalling, with both flags at 1, gives normal operation (status 2) on the next edge. In normal operation `outputs_en`, `analog_en` and `shadow_valid` are 1 and `recall_req` is 0.
- R5: From normal operation, the analog flag at 0 with the digital flag at 1 gives brownout-hold (status 3). Outputs and analog are disabled, `shadow_valid` stays 1 and `vol_clear` stays 0.
- R6: From brownout-hold, the analog flag back at 1 returns the block straight to normal operation, with no recall request.
- R7: The digital flag at 0 in any state leads to off. In off, `vol_clear` is 1 and `shadow_valid` is 0, and the next rise of both flags starts a new recall.
- R8: The analog flag at 1 together with the digital flag at 0 is treated as a supply below the digital level.
- R9: If `recall_done` and a synchronized digital flag of 0 reach the state logic in the same cycle, the block goes to off and `shadow_valid` stays 0.
- R10: `recall_done` while recalling, with only the digital flag at 1, marks the shadow bank valid and enters brownout-hold.
- R11: `recall_done` outside the recalling state has no effect on status or `shadow_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| above_pod | input | 1 | Asynchronous flag: supply above the digital reset level |
| above_poa | input | 1 | Asynchronous flag: supply above the analog reset level |
| recall_done | input | 1 | Nonvolatile store has finished copying into the shadow bank |
| recall_req | output | 1 | Request to copy the nonvolatile settings into the shadow bank |
| outputs_en | output | 1 | Device outputs enabled |
| analog_en | output | 1 | Analog circuitry enabled |
| vol_clear | output | 1 | Hold volatile settings at defaults and make shadow reads return zero |
| shadow_valid | output | 1 | Shadow bank holds a completed copy |
| status | output | 2 | 0 off, 1 recalling, 2 normal, 3 brownout-hold |

## Verification
Two events can land on the state logic in the same cycle. One is the completion of a recall, and the other is a synchronized supply loss below the digital level. The bench causes this by lowering the digital flag, waiting until that change has passed through both synchronizer flops, and then raising `recall_done` just before the edge at which the state register sees the synchronized value. The result is judged correct only if the block lands in off with the shadow bank still invalid. A second overlap occurs when a copy completes during an analog-only dip, and that case must end in brownout-hold with a valid bank.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RECALL = 2'd1,
    ST_NORMAL = 2'd2,
    ST_HOLD   = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2
  } sup_level_e;

  function automatic sup_level_e classify(input logic pod, input logic poa);
    if (!pod)      return LVL_LOW;
    else if (!poa) return LVL_MID;
    else           return LVL_HIGH;
  endfunction

endpackage

// File: rtl/supsv_rst_sync.sv
module supsv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/supsv_sync.sv
module supsv_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/supsv_fsm.sv
module supsv_fsm
  import supsv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sup_level_e level,
  input  logic       recall_done,
  output sup_state_e state_o,
  output logic       valid_o
);
  sup_state_e st_q, st_d;
  logic       val_q, val_d;
  logic       upd_en;

  always_comb begin
    st_d  = st_q;
    val_d = val_q;
    unique case (st_q)
      ST_OFF: begin
        val_d = 1'b0;
        if (level == LVL_HIGH) st_d = ST_RECALL;
      end
      ST_RECALL: begin
        if (level == LVL_LOW) begin
          st_d = ST_OFF;
        end else if (recall_done) begin
          val_d = 1'b1;
          st_d  = (level == LVL_HIGH) ? ST_NORMAL : ST_HOLD;
        end
      end
      ST_NORMAL: begin
        if (level == LVL_LOW)      st_d = ST_OFF;
        else if (level == LVL_MID) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (level == LVL_LOW)       st_d = ST_OFF;
        else if (level == LVL_HIGH) st_d = ST_NORMAL;
      end
      default: st_d = ST_OFF;
    endcase
    if (level == LVL_LOW) val_d = 1'b0;
  end

  assign upd_en = (st_d != st_q) || (val_d != val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      val_q <= 1'b0;
    end else if (upd_en) begin
      st_q  <= st_d;
      val_q <= val_d;
    end
  end

  assign state_o = st_q;
  assign valid_o = val_q;
endmodule

// File: rtl/supsv_decode.sv
module supsv_decode
  import supsv_pkg::*;
(
  input  sup_state_e state,
  output logic       recall_req,
  output logic       run_en,
  output logic       clear_en
);
  always_comb begin
    recall_req = 1'b0;
    run_en     = 1'b0;
    clear_en   = 1'b0;
    unique case (state)
      ST_OFF:    clear_en   = 1'b1;
      ST_RECALL: recall_req = 1'b1;
      ST_NORMAL: run_en     = 1'b1;
      ST_HOLD:   ;
      default:   clear_en   = 1'b1;
    endcase
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_pod,
  input  logic       above_poa,
  input  logic       recall_done,
  output logic       recall_req,
  output logic       outputs_en,
  output logic       analog_en,
  output logic       vol_clear,
  output logic       shadow_valid,
  output logic [1:0] status
);
  localparam int FLAG_W = 2;

  logic              core_rst_n;
  logic [FLAG_W-1:0] flags_s;
  sup_level_e        level;
  sup_state_e        state;
  logic              run_en;

  supsv_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  supsv_sync #(.STAGES(SYNC_STAGES), .WIDTH(FLAG_W)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     ({above_poa, above_pod}),
    .q     (flags_s)
  );

  assign level = classify(flags_s[0], flags_s[1]);

  supsv_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .level       (level),
    .recall_done (recall_done),
    .state_o     (state),
    .valid_o     (shadow_valid)
  );

  supsv_decode u_dec (
    .state      (state),
    .recall_req (recall_req),
    .run_en     (run_en),
    .clear_en   (vol_clear)
  );

  assign outputs_en = run_en;
  assign analog_en  = run_en;
  assign status     = state;
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       recall_done,
  input logic       recall_req,
  input logic       outputs_en,
  input logic       analog_en,
  input logic       vol_clear,
  input logic       shadow_valid,
  input logic [1:0] status
);
  // R3
  recall_blocks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> (!outputs_en && !analog_en));

  // R4
  run_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_en |-> shadow_valid);

  // R4
  valid_rise_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shadow_valid) |-> $past(recall_req && recall_done));

  // R5
  hold_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3) |-> (shadow_valid && !vol_clear && !outputs_en));

  // R6
  hold_exit_no_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == 2'd3 && status != 2'd3) |-> (status != 2'd1));

  // R7
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0) |-> (!shadow_valid && vol_clear));
endmodule

bind supply_supervisor supply_supervisor_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .recall_done  (recall_done),
  .recall_req   (recall_req),
  .outputs_en   (outputs_en),
  .analog_en    (analog_en),
  .vol_clear    (vol_clear),
  .shadow_valid (shadow_valid),
  .status       (status)
);

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb_top;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       above_pod;
  logic       above_poa;
  logic       recall_done;
  logic       recall_req;
  logic       outputs_en;
  logic       analog_en;
  logic       vol_clear;
  logic       shadow_valid;
  logic [1:0] status;

  int n_run;
  int n_fail;
  bit finished;

  supply_supervisor dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .above_pod    (above_pod),
    .above_poa    (above_poa),
    .recall_done  (recall_done),
    .recall_req   (recall_req),
    .outputs_en   (outputs_en),
    .analog_en    (analog_en),
    .vol_clear    (vol_clear),
    .shadow_valid (shadow_valid),
    .status       (status)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // packed: {status, outputs_en, analog_en, recall_req, vol_clear, shadow_valid}
  task automatic expect_out(input string req, input logic [1:0] st, input logic oe,
                            input logic ae, input logic rq, input logic vc, input logic sv);
    logic [6:0] act, exp;
    act = {status, outputs_en, analog_en, recall_req, vol_clear, shadow_valid};
    exp = {st, oe, ae, rq, vc, sv};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    // R1
    expect_out("R1", 2'd0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_power_up();
    above_pod = 1'b1; above_poa = 1'b1;
    tick(2);
    expect_out("R2", 2'd0, 0, 0, 0, 1, 0);
    tick(1);
    expect_out("R3", 2'd1, 0, 0, 1, 0, 0);
    tick(4);
    expect_out("R3", 2'd1, 0, 0, 1, 0, 0);
    recall_done = 1'b1;
    tick(1);
    recall_done = 1'b0;
    expect_out("R4", 2'd2, 1, 1, 0, 0, 1);
  endtask

  task automatic t_shallow_dip();
    above_poa = 1'b0;
    tick(3);
    expect_out("R5", 2'd3, 0, 0, 0, 0, 1);
    above_poa = 1'b1;
    tick(2);
    expect_out("R2", 2'd3, 0, 0, 0, 0, 1);
    tick(1);
    expect_out("R6", 2'd2, 1, 1, 0, 0, 1);
  endtask

  task automatic finish_recall();
    recall_done = 1'b1;
    tick(1);
    recall_done = 1'b0;
  endtask

  task automatic t_deep_drop();
    above_pod = 1'b0; above_poa = 1'b0;
    tick(3);
    expect_out("R7", 2'd0, 0, 0, 0, 1, 0);
    above_pod = 1'b1; above_poa = 1'b1;
    tick(3);
    expect_out("R7", 2'd1, 0, 0, 1, 0, 0);
    finish_recall();
    expect_out("R4", 2'd2, 1, 1, 0, 0, 1);
  endtask

  task automatic t_bad_combo();
    above_pod = 1'b0; above_poa = 1'b1;
    tick(3);
    expect_out("R8", 2'd0, 0, 0, 0, 1, 0);
    above_pod = 1'b1;
    tick(3);
    expect_out("R8", 2'd1, 0, 0, 1, 0, 0);
  endtask

  task automatic t_collide();
    // block is recalling here
    above_pod = 1'b0;
    tick(2);
    recall_done = 1'b1;
    tick(1);
    recall_done = 1'b0;
    expect_out("R9", 2'd0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_done_in_dip();
    above_pod = 1'b1; above_poa = 1'b1;
    tick(3);
    expect_out("R3", 2'd1, 0, 0, 1, 0, 0);
    above_poa = 1'b0;
    tick(3);
    expect_out("R10", 2'd1, 0, 0, 1, 0, 0);
    finish_recall();
    expect_out("R10", 2'd3, 0, 0, 0, 0, 1);
    above_poa = 1'b1;
    tick(3);
    expect_out("R6", 2'd2, 1, 1, 0, 0, 1);
  endtask

  task automatic t_stray_done();
    recall_done = 1'b1;
    tick(3);
    expect_out("R11", 2'd2, 1, 1, 0, 0, 1);
    recall_done = 1'b0;
    above_poa = 1'b0;
    tick(3);
    recall_done = 1'b1;
    tick(2);
    expect_out("R11", 2'd3, 0, 0, 0, 0, 1);
    recall_done = 1'b0;
    above_pod = 1'b0; above_poa = 1'b0;
    tick(3);
    recall_done = 1'b1;
    tick(2);
    expect_out("R11", 2'd0, 0, 0, 0, 1, 0);
    recall_done = 1'b0;
    tick(1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; above_pod = 1'b0; above_poa = 1'b0; recall_done = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_power_up();
    t_shallow_dip();
    t_deep_drop();
    t_bad_combo();
    t_collide();
    t_done_in_dip();
    t_stray_done();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule